// File: doc/BRIEF.md
# Asynchronous DRAM Row/Column Strobe Sequencer

This block sits between a simple host request port and an asynchronous, page-less DRAM of 256K bytes that has nine multiplexed address pins and a shared bidirectional byte-wide data bus. For each host request it places the row half of the address on the pins and drops the row strobe. It then swaps in the column half and drops the column strobe. It drives the output-enable or write-enable strobe and returns read data once both access-time minimums have elapsed.

The host picks early or late strobe ordering per request. In early ordering the data strobe (OE for reads, WE for writes) falls before the column strobe. In late ordering it falls only after the column strobe has fallen. A separate refresh request performs a row-only dummy access that restores one row. All DRAM timing limits are given in nanoseconds and turned into clock counts, rounded up, from the clock-period parameter. With the defaults of 10 ns clock, 60 ns row access, 15 ns column access and 110 ns row cycle, the counts are 6, 2 and 11 cycles.

Top module: `dram_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, all four strobes (`dram_ras_l`, `dram_cas_l`, `dram_oe_l`, `dram_we_l`, active low) are high, `busy` is low and `rvalid` is low.
- R2: The row field `addr[17:9]` is on `dram_a` at least one clock before `dram_ras_l` falls and stays there through the fall. The column field `addr[8:0]` is likewise on `dram_a` before and at the fall of `dram_cas_l`. `dram_cas_l` is low only while `dram_ras_l` is low.
- R3: A read (`we`=0) with `early_mode`=1 drives `dram_oe_l` low before `dram_cas_l` falls.
- R4: A read with `early_mode`=0 keeps `dram_oe_l` high until after `dram_cas_l` has fallen, and then drives it low.
- R5: A write (`we`=1) with `early_mode`=1 drives `dram_we_l` low before `dram_cas_l` falls, with `wdata` on `dram_dq`. The byte is stored at `addr`.
- R6: A write with `early_mode`=0 keeps `dram_we_l` high until after `dram_cas_l` has fallen, then drives it low with `wdata` on `dram_dq`. The byte is stored at `addr`.
- R7: Read data is taken from `dram_dq` at a clock edge that is at least the row access time after the `dram_ras_l` fall and at least the column access time after the `dram_cas_l` fall. It is then presented on `rdata` with `rvalid` high for exactly one cycle. `rdata` equals the byte stored at `addr`.
- R8: Successive falls of `dram_ras_l` are at least the row cycle time apart. When requests are back to back, the gap is exactly that time rounded up to whole clocks.
- R9: `refresh_req` is taken ahead of a simultaneous `req` when idle. It produces a row-only cycle on row `addr[17:9]`, with `dram_ras_l` low for at least the row access time and no fall of `dram_cas_l`, `dram_oe_l` or `dram_we_l`. The held `req` is served afterwards.
- R10: `dram_oe_l` and `dram_we_l` are never low together. Every cycle ends with `dram_oe_l`, `dram_we_l` and `dram_cas_l` high at the clock where `dram_ras_l` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, taken at an edge with `busy` low |
| we | input | 1 | 1 = write, 0 = read |
| early_mode | input | 1 | 1 = early strobe ordering, 0 = late |
| addr | input | 18 | Byte address: row in [17:9], column in [8:0] |
| wdata | input | 8 | Write byte |
| refresh_req | input | 1 | Row-only refresh request, priority over `req` |
| busy | output | 1 | Sequencer is running a cycle |
| rvalid | output | 1 | One-cycle pulse with read data |
| rdata | output | 8 | Read byte |
| dram_a | output | 9 | Multiplexed row/column address pins |
| dram_ras_l | output | 1 | Row strobe, active low |
| dram_cas_l | output | 1 | Column strobe, active low |
| dram_we_l | output | 1 | Write strobe, active low |
| dram_oe_l | output | 1 | Output enable, active low |
| dram_dq | inout | 8 | Shared data bus |

## Verification
The bench's DRAM model latches the row and column on the strobe edges and records whether OE or WE was already low when CAS fell. A design that swapped early and late ordering would show the wrong strobe state at the CAS edge. A design that changed the address pins at the strobe edge would latch the wrong row or column, and the read-back would miss. The model times each RAS fall against the previous one and against the `rvalid` edge, so a counter limit off by one clock shows up as a 100 ns row cycle or a 50 ns row access. A refresh issued together with a read checks that the row-only cycle comes first, carries no column strobe, and that the read still completes after it.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a request
    ST_ROW,    // row on pins, waiting for setup and row cycle
    ST_RAS,    // row strobe low, row held
    ST_COL,    // column on pins, early data strobe
    ST_CAS,    // column strobe low
    ST_STRB,   // data strobe low, waiting for access times
    ST_RFSH,   // row-only refresh hold
    ST_DONE    // all strobes released
  } seq_state_t;

  // Nanosecond limit to clock count, rounded up.
  function automatic int ns_to_cycles(input int limit_ns, input int clk_ns);
    return (limit_ns + clk_ns - 1) / clk_ns;
  endfunction

  // Bits needed for a saturating age counter that reaches sat.
  function automatic int age_width(input int sat);
    return (sat < 1) ? 1 : $clog2(sat + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_seq_age.sv
`timescale 1ns/1ps
// Saturating count of clocks since the last restart edge.
module dram_seq_age #(
  parameter int SAT       = 11,
  parameter bit INIT_FULL = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   restart,
  output logic [dram_seq_pkg::age_width(SAT)-1:0] age
);
  localparam int W = dram_seq_pkg::age_width(SAT);
  localparam logic [W-1:0] TOP = W'(SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= INIT_FULL ? TOP : '0;
    else if (restart)  age <= W'(1);
    else if (age != TOP) age <= age + 1'b1;
  end
endmodule

// File: rtl/dram_seq_pins.sv
`timescale 1ns/1ps
// Decodes the sequencer state into pin levels.
module dram_seq_pins
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int PIN_W = 9
) (
  input  seq_state_t       state,
  input  logic             early,
  input  logic             is_write,
  input  logic             is_refresh,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic [PIN_W-1:0] a_pins,
  output logic             ras_l,
  output logic             cas_l,
  output logic             oe_l,
  output logic             we_l,
  output logic             dq_drive
);
  logic col_phase;
  logic strobe_on;

  always_comb begin
    col_phase = !is_refresh &&
                (state == ST_COL || state == ST_CAS ||
                 state == ST_STRB || state == ST_DONE);
    strobe_on = (state == ST_STRB) ||
                (early && (state == ST_COL || state == ST_CAS));
    a_pins    = col_phase ? PIN_W'(col) : PIN_W'(row);
    ras_l     = !(state == ST_RAS || state == ST_COL || state == ST_CAS ||
                  state == ST_STRB || state == ST_RFSH);
    cas_l     = !(state == ST_CAS || state == ST_STRB);
    oe_l      = !(strobe_on && !is_write);
    we_l      = !(strobe_on && is_write);
    dq_drive  = strobe_on && is_write;
  end
endmodule

// File: rtl/dram_seq.sv
`timescale 1ns/1ps
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W         = 9,
  parameter int COL_W         = 9,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RAC_NS      = 60,
  parameter int T_CAC_NS      = 15,
  parameter int T_RC_NS       = 110
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    we,
  input  logic                    early_mode,
  input  logic [ROW_W+COL_W-1:0]  addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    refresh_req,
  output logic                    busy,
  output logic                    rvalid,
  output logic [DATA_W-1:0]       rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
  output logic                    dram_ras_l,
  output logic                    dram_cas_l,
  output logic                    dram_we_l,
  output logic                    dram_oe_l,
  inout  wire  [DATA_W-1:0]       dram_dq
);
  localparam int ADDR_W  = ROW_W + COL_W;
  localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RAC_CYC = ns_to_cycles(T_RAC_NS, CLK_PERIOD_NS);
  localparam int CAC_CYC = ns_to_cycles(T_CAC_NS, CLK_PERIOD_NS);
  localparam int RC_CYC  = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int RAS_SAT = max2(RC_CYC, RAC_CYC);
  localparam int RAS_AW  = age_width(RAS_SAT);
  localparam int CAS_AW  = age_width(CAC_CYC);

  seq_state_t state, state_nx;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic wr_q, early_q, rfsh_q, rvalid_q;

  logic [RAS_AW-1:0] since_ras;
  logic [CAS_AW-1:0] since_cas;

  // Named internal events.
  logic accept_ev, ras_fall_ev, cas_fall_ev, sample_ev, rfsh_end_ev;
  logic rc_met, rac_met, cac_met;
  logic dq_drive;

  assign rc_met      = since_ras >= RAS_AW'(RC_CYC);
  assign rac_met     = since_ras >= RAS_AW'(RAC_CYC);
  assign cac_met     = since_cas >= CAS_AW'(CAC_CYC);
  assign accept_ev   = (state == ST_IDLE) && (req || refresh_req);
  assign ras_fall_ev = (state == ST_ROW) && rc_met;
  assign cas_fall_ev = (state == ST_COL);
  assign sample_ev   = (state == ST_STRB) && rac_met && cac_met;
  assign rfsh_end_ev = (state == ST_RFSH) && rac_met;

  dram_seq_age #(.SAT(RAS_SAT), .INIT_FULL(1'b1)) u_ras_age (
    .clk(clk), .rst_n(rst_n), .restart(ras_fall_ev), .age(since_ras)
  );

  dram_seq_age #(.SAT(CAC_CYC), .INIT_FULL(1'b0)) u_cas_age (
    .clk(clk), .rst_n(rst_n), .restart(cas_fall_ev), .age(since_cas)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept_ev)   state_nx = ST_ROW;
      ST_ROW:  if (ras_fall_ev) state_nx = ST_RAS;
      ST_RAS:  state_nx = rfsh_q ? ST_RFSH : ST_COL;
      ST_COL:  state_nx = ST_CAS;
      ST_CAS:  state_nx = ST_STRB;
      ST_STRB: if (sample_ev)   state_nx = ST_DONE;
      ST_RFSH: if (rfsh_end_ev) state_nx = ST_DONE;
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      early_q  <= 1'b0;
      rfsh_q   <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state    <= state_nx;
      rvalid_q <= sample_ev && !wr_q;
      if (accept_ev) begin
        row_q   <= addr[ADDR_W-1:COL_W];
        col_q   <= addr[COL_W-1:0];
        wdata_q <= wdata;
        wr_q    <= we && !refresh_req;
        early_q <= early_mode;
        rfsh_q  <= refresh_req;
      end
      if (sample_ev && !wr_q) rdata_q <= dram_dq;
    end
  end

  dram_seq_pins #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_pins (
    .state      (state),
    .early      (early_q),
    .is_write   (wr_q),
    .is_refresh (rfsh_q),
    .row        (row_q),
    .col        (col_q),
    .a_pins     (dram_a),
    .ras_l      (dram_ras_l),
    .cas_l      (dram_cas_l),
    .oe_l       (dram_oe_l),
    .we_l       (dram_we_l),
    .dq_drive   (dq_drive)
  );

  assign dram_dq = dq_drive ? wdata_q : {DATA_W{1'bz}};
  assign busy    = (state != ST_IDLE);
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/dram_seq_chk.sv
`timescale 1ns/1ps
module dram_seq_chk #(
  parameter int PIN_W  = 9,
  parameter int RC_CYC = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             rvalid,
  input logic             ras_l,
  input logic             cas_l,
  input logic             oe_l,
  input logic             we_l,
  input logic [PIN_W-1:0] a
);
  localparam int GW = $clog2(RC_CYC + 1);
  localparam logic [GW-1:0] GTOP = GW'(RC_CYC);

  logic          ras_prev;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev <= 1'b1;
      gap      <= GTOP;
    end else begin
      ras_prev <= ras_l;
      if (ras_prev && !ras_l) gap <= GW'(1);
      else if (gap != GTOP)   gap <= gap + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_l && cas_l && oe_l && we_l));

  a_r2_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_l) |-> $stable(a));

  a_r2_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_l) |-> $stable(a));

  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_l |-> !ras_l);

  a_r7_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  a_r8_row_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_prev && !ras_l) |-> (gap >= GTOP));

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_l && !we_l));

  a_r10_end_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_l) |-> (cas_l && oe_l && we_l));
endmodule

bind dram_seq dram_seq_chk #(.PIN_W(PIN_W), .RC_CYC(RC_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .rvalid (rvalid),
  .ras_l  (dram_ras_l),
  .cas_l  (dram_cas_l),
  .oe_l   (dram_oe_l),
  .we_l   (dram_we_l),
  .a      (dram_a)
);

// File: tb/dram_seq_tb.sv
`timescale 1ns/1ps
module dram_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam longint RAC_NS = 60;
  localparam longint CAC_NS = 15;
  localparam longint RC_NS  = 110;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, early_mode = 1'b0, refresh_req = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  wire         busy, rvalid;
  wire  [7:0]  rdata;
  wire  [8:0]  dram_a;
  wire         ras_l, cas_l, we_l, oe_l;
  wire  [7:0]  dq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .early_mode(early_mode),
    .addr(addr), .wdata(wdata), .refresh_req(refresh_req),
    .busy(busy), .rvalid(rvalid), .rdata(rdata),
    .dram_a(dram_a), .dram_ras_l(ras_l), .dram_cas_l(cas_l),
    .dram_we_l(we_l), .dram_oe_l(oe_l), .dram_dq(dq)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // ---------------- DRAM model ----------------
  logic [7:0] mem [int unsigned];
  logic [8:0] m_row = '0, m_col = '0;
  logic [7:0] m_out = '0;
  time t_ras = 0, t_cas = 0, last_gap = 0;
  bit  have_ras = 0;
  int  cas_falls = 0, rf_count = 0, ras_cycles = 0;
  bit  oe_pre = 0, we_pre = 0, oe_seen = 0, we_seen = 0;
  logic [8:0] rf_row = '0;
  time rf_dur = 0;
  int  kind_log [0:63];

  function automatic logic [7:0] mem_get(input int unsigned k);
    if (mem.exists(k)) return mem[k];
    return k[7:0] ^ 8'h5A;
  endfunction

  assign dq = (!oe_l && we_l && !cas_l && !ras_l) ? m_out : 8'bz;

  always @(negedge ras_l) begin
    m_row = dram_a;
    if (have_ras) begin
      last_gap = $time - t_ras;
      check(last_gap >= RC_NS, "R8", "ras-to-ras ns", longint'(last_gap), RC_NS);
    end
    t_ras = $time; have_ras = 1;
    cas_falls = 0; oe_seen = 0; we_seen = 0;
  end

  always @(negedge cas_l) begin
    m_col = dram_a;
    t_cas = $time;
    cas_falls++;
    oe_pre = !oe_l;
    we_pre = !we_l;
    m_out  = mem_get({m_row, m_col});
  end

  always @(negedge cas_l) begin
    #1;
    if (!we_l && !ras_l) mem[{m_row, m_col}] = dq;
  end

  always @(negedge we_l) begin
    we_seen = 1;
    #1;
    if (!cas_l && !ras_l) mem[{m_row, m_col}] = dq;
  end

  always @(negedge oe_l) oe_seen = 1;

  always @(posedge ras_l) begin
    if (have_ras) begin
      if (cas_falls == 0) begin
        rf_count++; rf_row = m_row; rf_dur = $time - t_ras;
        kind_log[ras_cycles % 64] = 0;
      end else begin
        kind_log[ras_cycles % 64] = 1;
      end
      ras_cycles++;
    end
  end

  always @(posedge rvalid) begin
    if (have_ras) begin
      check(($time - t_ras) >= RAC_NS, "R7", "ras fall to sample ns",
            longint'($time - t_ras), RAC_NS);
      check(($time - t_cas) >= CAC_NS, "R7", "cas fall to sample ns",
            longint'($time - t_cas), CAC_NS);
    end
  end

  // ---------------- host tasks ----------------
  task automatic access(input bit w, input bit e, input logic [17:0] a,
                        input logic [7:0] d, output logic [7:0] rd,
                        output int pulses);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; we = w; early_mode = e; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    rd = '0; pulses = 0;
    while (busy) begin
      if (rvalid) begin rd = rdata; pulses++; end
      @(negedge clk);
    end
  endtask

  task automatic idle_pins(input string rq);
    check(ras_l && cas_l && oe_l && we_l, rq, "strobes high when idle",
          {ras_l, cas_l, oe_l, we_l}, 4'b1111);
  endtask

  task automatic t_reset;
    @(negedge clk);
    idle_pins("R1");
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(rvalid == 0, "R1", "rvalid after reset", rvalid, 0);
  endtask

  task automatic t_write(input bit e, input logic [17:0] a, input logic [7:0] d);
    logic [7:0] rd; int p;
    string rq;
    rq = e ? "R5" : "R6";
    access(1, e, a, d, rd, p);
    check(m_row == a[17:9], "R2", "row latched", m_row, a[17:9]);
    check(m_col == a[8:0], "R2", "col latched", m_col, a[8:0]);
    check(we_pre == e, rq, "we low at cas fall", we_pre, e);
    check(we_seen == 1, rq, "we strobe seen", we_seen, 1);
    check(oe_seen == 0, "R10", "no oe during write", oe_seen, 0);
    check(mem_get({a[17:9], a[8:0]}) == d, rq, "stored byte",
          mem_get(a), d);
    check(p == 0, rq, "no rvalid on write", p, 0);
    idle_pins("R10");
  endtask

  task automatic t_read(input bit e, input logic [17:0] a);
    logic [7:0] rd, exp; int p;
    string rq;
    rq = e ? "R3" : "R4";
    exp = mem_get(a);
    access(0, e, a, 8'h00, rd, p);
    check(m_row == a[17:9], "R2", "row latched", m_row, a[17:9]);
    check(m_col == a[8:0], "R2", "col latched", m_col, a[8:0]);
    check(oe_pre == e, rq, "oe low at cas fall", oe_pre, e);
    check(oe_seen == 1, rq, "oe strobe seen", oe_seen, 1);
    check(we_seen == 0, "R10", "no we during read", we_seen, 0);
    check(p == 1, "R7", "rvalid pulses", p, 1);
    check(rd == exp, "R7", "read data", rd, exp);
    idle_pins("R10");
  endtask

  task automatic t_back_to_back;
    logic [7:0] rd; int p;
    access(0, 1, 18'h2_0101, 8'h00, rd, p);
    access(0, 0, 18'h1_1F0E, 8'h00, rd, p);
    check(last_gap == RC_NS, "R8", "back-to-back row cycle ns",
          longint'(last_gap), RC_NS);
  endtask

  task automatic t_refresh_priority;
    int rf0, n0, p;
    logic [7:0] rd, exp;
    logic [17:0] a;
    a = 18'h3_A5C3;
    exp = mem_get(a);
    rf0 = rf_count; n0 = ras_cycles;
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; we = 0; early_mode = 1; addr = a; refresh_req = 1;
    @(negedge clk);
    refresh_req = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    req = 0;
    rd = '0; p = 0;
    while (busy) begin
      if (rvalid) begin rd = rdata; p++; end
      @(negedge clk);
    end
    check(rf_count == rf0 + 1, "R9", "refresh count", rf_count, rf0 + 1);
    check(rf_row == a[17:9], "R9", "refresh row", rf_row, a[17:9]);
    check(rf_dur >= RAC_NS, "R9", "refresh ras low ns", longint'(rf_dur), RAC_NS);
    check(kind_log[n0 % 64] == 0, "R9", "first cycle is refresh", kind_log[n0 % 64], 0);
    check(kind_log[(n0 + 1) % 64] == 1, "R9", "held req served next",
          kind_log[(n0 + 1) % 64], 1);
    check(p == 1 && rd == exp, "R9", "read after refresh", rd, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write(1, 18'h0_0000, 8'hC3);
    t_read (1, 18'h0_0000);
    t_write(0, 18'h3_FFFF, 8'h3C);
    t_read (0, 18'h3_FFFF);
    t_write(1, 18'h1_5A5A, 8'h81);
    t_read (0, 18'h1_5A5A);
    t_write(0, 18'h1_5A5A, 8'h7E);
    t_read (1, 18'h1_5A5A);
    t_read (1, 18'h2_4321);
    t_back_to_back();
    t_refresh_priority();
    t_reset();
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule